// File: doc/BRIEF.md
# Register-Mapped Streaming FIR Filter

This block puts a small direct-form FIR filter behind a plain register port, so that a processor can reach it with ordinary loads and stores. A store to the sample register queues an 8-bit sample in an input FIFO. The FIFO feeds a chain of tap cells, one cell per coefficient, over a valid/ready handshake. Each filtered result goes into an output FIFO, and a load from the result register takes it out. Software can read the occupancy of either FIFO at any time.

The chain moves only when the input FIFO supplies a sample and the output FIFO can take a result. Every accepted sample shifts all taps at once. When a FIFO cannot serve an access to its data register, the port raises a wait signal and holds the access until it can complete. It does not return an error.

Samples, coefficients and results are signed fixed point with 3 fraction bits. The default taps are 1.0, 2.0 and 3.0.

Top module: `fir_stream_periph`

## Requirements
- R1: A write to address 0x2000 that completes puts `bus_wdata[7:0]` into the input FIFO. A read of 0x2008 returns that FIFO's occupancy, zero-extended to 64 bits.
- R2: A read of 0x2100 that completes removes the oldest result from the output FIFO and returns it in bits [7:0], with all upper bits zero. A read of 0x2108 returns the output FIFO's occupancy.
- R3: Each FIFO holds 8 entries. While the input FIFO holds 8 entries, a write to 0x2000 keeps `bus_stall` high and adds nothing, so the occupancy stays at 8.
- R4: While the output FIFO is empty, a read of 0x2100 keeps `bus_stall` high.
- R5: With raw coefficients 8, 16 and 24 (1.0, 2.0, 3.0 with 3 fraction bits) applied from the first tap to the last, the result for samples x[n], x[n+1], x[n+2] is (3·x[n] + 2·x[n+1] + x[n+2]) mod 256. A product is shifted right arithmetically by 3 and cut to 8 bits before it is added, and every sum wraps.
- R6: A result is produced only when the chain accepts a sample while all 3 taps already hold one. With 3 taps, the k-th accepted sample yields a result only for k ≥ 4, and results leave in sample order.
- R7: While the output FIFO is full, the chain does not advance. Samples wait in the input FIFO and none is lost or repeated once reads resume.
- R8: Reset empties both FIFOs and clears every tap. After reset, 3 more samples are needed before any result appears.
- R9: A read of any address other than 0x2008, 0x2100 and 0x2108 returns zero and never stalls. A write to any address other than 0x2000 has no effect on either FIFO.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bus_req | input | 1 | Access request, held until the access completes |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Byte address |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data, valid in the cycle the read completes |
| bus_stall | output | 1 | Wait; the access completes on the first rising edge with `bus_req` high and this low |

## Verification
The hardest state to reach is the write stall. It needs the whole path to back up: the output FIFO full, the taps frozen and the input FIFO full. The stimulus writes 19 samples with no reads in between, lets the chain settle, and then holds a twentieth write to confirm the wait signal and the unchanged occupancies. After that it drains all 16 results and compares them against the model. Random rounds of 1 to 8 samples, a reset in the middle of priming and writes to every unused address cover the rest.

// File: rtl/fir_periph_pkg.sv
package fir_periph_pkg;

    // Register selected by the current bus address
    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_IN_DATA,
        SEL_IN_CNT,
        SEL_OUT_DATA,
        SEL_OUT_CNT
    } reg_sel_e;

endpackage

// File: rtl/fir_fifo.sv
module fir_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic          full,
    output logic          empty,
    output logic [CW-1:0] count
);
    typedef struct packed {
        logic [AW-1:0] rd;
        logic [AW-1:0] wr;
        logic [CW-1:0] cnt;
    } ptr_t;

    ptr_t st_d, st_q;
    logic [W-1:0] mem_d [DEPTH];
    logic [W-1:0] mem_q [DEPTH];

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d  = st_q;
        mem_d = mem_q;
        if (push) begin
            mem_d[st_q.wr] = din;
            st_d.wr        = nxt(st_q.wr);
        end
        if (pop) st_d.rd = nxt(st_q.rd);
        if (push && !pop) st_d.cnt = st_q.cnt + 1'b1;
        else if (pop && !push) st_d.cnt = st_q.cnt - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
        mem_q <= mem_d;
    end

    assign dout  = mem_q[st_q.rd];
    assign count = st_q.cnt;
    assign full  = (st_q.cnt == CW'(DEPTH));
    assign empty = (st_q.cnt == '0);

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        !(push && full && !pop));
    // R3
    no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
        !(pop && empty));
    // R3
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));
endmodule

// File: rtl/fir_tap.sv
module fir_tap #(
    parameter int              W    = 8,
    parameter int              FRAC = 3,
    parameter logic [W-1:0]    COEF = 8'd8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_smp,
    input  logic [W-1:0] in_sum,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_smp,
    output logic [W-1:0] out_sum
);
    typedef struct packed {
        logic         has;
        logic [W-1:0] smp;
    } tap_t;

    tap_t tap_d, tap_q;
    logic               fire;
    logic signed [2*W-1:0] prod;
    logic signed [2*W-1:0] scaled;
    logic [2*W-W-1:0]   unused_hi;

    assign in_ready = out_ready;
    assign fire     = in_valid && in_ready;

    always_comb begin
        tap_d = tap_q;
        if (fire) begin
            tap_d.has = 1'b1;
            tap_d.smp = in_smp;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) tap_q <= '0;
        else     tap_q <= tap_d;
    end

    assign prod      = $signed({{W{tap_q.smp[W-1]}}, tap_q.smp})
                     * $signed({{W{COEF[W-1]}}, COEF});
    assign scaled    = prod >>> FRAC;
    assign unused_hi = scaled[2*W-1:W];
    assign out_valid = tap_q.has && fire;
    assign out_smp   = tap_q.smp;
    assign out_sum   = in_sum + scaled[W-1:0];

    // R6
    tap_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !fire |=> $stable(out_smp));
endmodule

// File: rtl/fir_tap_chain.sv
module fir_tap_chain #(
    parameter int                  W      = 8,
    parameter int                  FRAC   = 3,
    parameter int                  NTAPS  = 3,
    parameter logic [NTAPS*W-1:0]  COEFS  = {8'd24, 8'd16, 8'd8}
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_smp,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data
);
    logic         v   [NTAPS+1];
    logic         r   [NTAPS+1];
    logic [W-1:0] smp [NTAPS+1];
    logic [W-1:0] sum [NTAPS+1];
    logic [W-1:0] unused_smp;

    assign v[0]       = in_valid;
    assign smp[0]     = in_smp;
    assign sum[0]     = '0;
    assign in_ready   = r[0];
    assign r[NTAPS]   = out_ready;
    assign out_valid  = v[NTAPS];
    assign out_data   = sum[NTAPS];
    assign unused_smp = smp[NTAPS];

    for (genvar i = 0; i < NTAPS; i++) begin : g_tap
        fir_tap #(
            .W    (W),
            .FRAC (FRAC),
            .COEF (COEFS[i*W +: W])
        ) u_tap (
            .clk       (clk),
            .rst       (rst),
            .in_valid  (v[i]),
            .in_ready  (r[i]),
            .in_smp    (smp[i]),
            .in_sum    (sum[i]),
            .out_valid (v[i+1]),
            .out_ready (r[i+1]),
            .out_smp   (smp[i+1]),
            .out_sum   (sum[i+1])
        );
    end

    // R6
    shift_on_accept_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (in_valid && in_ready));
    // R7
    hold_when_blocked_chk: assert property (@(posedge clk) disable iff (rst)
        !out_ready |-> !out_valid);
endmodule

// File: rtl/fir_stream_periph.sv
module fir_stream_periph
    import fir_periph_pkg::*;
#(
    parameter int                     BUS_W   = 64,
    parameter int                     ADDR_W  = 16,
    parameter int                     SMP_W   = 8,
    parameter int                     FRAC    = 3,
    parameter int                     DEPTH   = 8,
    parameter int                     NTAPS   = 3,
    parameter logic [NTAPS*SMP_W-1:0] COEFS   = {8'd24, 8'd16, 8'd8},
    parameter logic [ADDR_W-1:0]      WR_BASE = 16'h2000,
    parameter logic [ADDR_W-1:0]      RD_BASE = 16'h2100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              bus_stall
);
    localparam int CW      = $clog2(DEPTH + 1);
    localparam int CNT_OFS = (BUS_W + 7) / 8;

    reg_sel_e         sel;
    logic             in_push, in_pop, in_full, in_empty;
    logic             out_push, out_pop, out_full, out_empty;
    logic [SMP_W-1:0] in_dout, out_din, out_dout;
    logic [CW-1:0]    in_cnt, out_cnt;
    logic             chain_ready;
    logic [BUS_W-SMP_W-1:0] unused_wdata;

    assign unused_wdata = bus_wdata[BUS_W-1:SMP_W];

    always_comb begin
        if      (bus_addr == WR_BASE)                   sel = SEL_IN_DATA;
        else if (bus_addr == WR_BASE + ADDR_W'(CNT_OFS)) sel = SEL_IN_CNT;
        else if (bus_addr == RD_BASE)                   sel = SEL_OUT_DATA;
        else if (bus_addr == RD_BASE + ADDR_W'(CNT_OFS)) sel = SEL_OUT_CNT;
        else                                            sel = SEL_NONE;
    end

    always_comb begin
        in_push   = bus_req && bus_we && (sel == SEL_IN_DATA) && !in_full;
        out_pop   = bus_req && !bus_we && (sel == SEL_OUT_DATA) && !out_empty;
        bus_stall = bus_req && ((bus_we && (sel == SEL_IN_DATA) && in_full) ||
                                (!bus_we && (sel == SEL_OUT_DATA) && out_empty));
        bus_rdata = '0;
        if (bus_req && !bus_we) begin
            case (sel)
                SEL_IN_CNT:   bus_rdata = BUS_W'(in_cnt);
                SEL_OUT_CNT:  bus_rdata = BUS_W'(out_cnt);
                SEL_OUT_DATA: if (!out_empty) bus_rdata = BUS_W'(out_dout);
                default:      bus_rdata = '0;
            endcase
        end
    end

    fir_fifo #(.W(SMP_W), .DEPTH(DEPTH)) u_in_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (in_push),
        .din   (bus_wdata[SMP_W-1:0]),
        .pop   (in_pop),
        .dout  (in_dout),
        .full  (in_full),
        .empty (in_empty),
        .count (in_cnt)
    );

    fir_tap_chain #(
        .W     (SMP_W),
        .FRAC  (FRAC),
        .NTAPS (NTAPS),
        .COEFS (COEFS)
    ) u_chain (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (!in_empty),
        .in_ready  (chain_ready),
        .in_smp    (in_dout),
        .out_valid (out_push),
        .out_ready (!out_full),
        .out_data  (out_din)
    );

    assign in_pop = !in_empty && chain_ready;

    fir_fifo #(.W(SMP_W), .DEPTH(DEPTH)) u_out_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (out_push),
        .din   (out_din),
        .pop   (out_pop),
        .dout  (out_dout),
        .full  (out_full),
        .empty (out_empty),
        .count (out_cnt)
    );

    // R3
    stall_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
        bus_stall |-> bus_req);
    // R9
    unmapped_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_req && sel == SEL_NONE) |-> (!bus_stall && bus_rdata == '0));
    // R8
    reset_empty_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (in_cnt == '0 && out_cnt == '0));
    // R7
    blocked_no_drain_chk: assert property (@(posedge clk) disable iff (rst)
        (out_full && !out_pop) |=> $stable(out_cnt) || $past(out_pop));
endmodule

// File: tb/tb_fir_stream_periph.sv
module tb_fir_stream_periph;
    logic        clk = 1'b0;
    logic        rst;
    logic        bus_req;
    logic        bus_we;
    logic [15:0] bus_addr;
    logic [63:0] bus_wdata;
    logic [63:0] bus_rdata;
    logic        bus_stall;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    int smp_q[$];
    int popped = 0;

    always #5 clk = ~clk;

    fir_stream_periph dut (
        .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_stall(bus_stall)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int produced();
        return (smp_q.size() > 3) ? smp_q.size() - 3 : 0;
    endfunction

    function automatic int exp_res(input int n);
        return (3 * smp_q[n] + 2 * smp_q[n+1] + smp_q[n+2]) & 255;
    endfunction

    task automatic bus_write(input logic [15:0] a, input logic [63:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        #1;
        while (bus_stall) begin @(negedge clk); #1; end
        @(posedge clk); #1;
        bus_req = 1'b0;
    endtask

    task automatic bus_read(input logic [15:0] a, output logic [63:0] d,
                            output bit stalled);
        stalled = 1'b0;
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1;
        while (bus_stall) begin stalled = 1'b1; @(negedge clk); #1; end
        d = bus_rdata;
        @(posedge clk); #1;
        bus_req = 1'b0;
    endtask

    task automatic push_smp(input int v);
        bus_write(16'h2000, {$urandom(), $urandom()} & 64'hFFFF_FFFF_FFFF_FF00 | 64'(v));
        smp_q.push_back(v);
    endtask

    task automatic check_counts(input string req, input int e_in, input int e_out);
        logic [63:0] d; bit s;
        bus_read(16'h2008, d, s); chk({req, " in count"}, d, e_in);
        bus_read(16'h2108, d, s); chk({req, " out count"}, d, e_out);
    endtask

    task automatic drain_all(input string req);
        logic [63:0] d; bit s;
        while (popped < produced()) begin
            bus_read(16'h2100, d, s);
            chk({req, " result"}, d, exp_res(popped));
            popped++;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        smp_q.delete();
        popped = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [63:0] d;
        bit s;
        void'($urandom(32'd1234));
        rst = 1'b1; bus_req = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
        do_reset();

        // R8 reset state
        check_counts("R8 reset", 0, 0);

        // R4 empty read stalls
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = 16'h2100;
        for (int i = 0; i < 3; i++) begin
            #1; chk("R4 stall on empty", bus_stall, 1); @(negedge clk);
        end
        bus_req = 1'b0;

        // R9 unmapped reads return zero, no stall
        bus_read(16'h2000, d, s); chk("R9 read wdata reg", d, 0); chk("R9 no stall", s, 0);
        bus_read(16'h2250, d, s); chk("R9 read unmapped", d, 0); chk("R9 no stall", s, 0);

        // R5/R6 directed: priming then first result
        push_smp(8'h10); push_smp(8'h03); push_smp(8'hF0);
        repeat (10) @(posedge clk);
        check_counts("R6 primed", 0, 0);
        push_smp(8'h7F);
        repeat (10) @(posedge clk);
        check_counts("R6 first", 0, 1);
        drain_all("R5 directed");

        // R9 writes elsewhere ignored
        bus_write(16'h2008, 64'h5); bus_write(16'h2100, 64'h6);
        bus_write(16'h2108, 64'h7); bus_write(16'h2040, 64'h8);
        repeat (6) @(posedge clk);
        check_counts("R9 writes ignored", 0, 0);

        // R1/R2/R5 random rounds
        for (int r = 0; r < 20; r++) begin
            int k = $urandom_range(1, 8);
            for (int j = 0; j < k; j++) push_smp($urandom_range(0, 255));
            repeat (12) @(posedge clk);
            check_counts("R1 R2 round", 0, produced() - popped);
            drain_all("R5 random");
        end

        // R8 reset in the middle of priming
        push_smp(8'h11); push_smp(8'h22);
        do_reset();
        check_counts("R8 cleared", 0, 0);
        push_smp(8'h05); push_smp(8'h06); push_smp(8'h07);
        repeat (10) @(posedge clk);
        check_counts("R8 reprime", 0, 0);
        push_smp(8'h08);
        repeat (10) @(posedge clk);
        check_counts("R8 after prime", 0, 1);
        drain_all("R8 result");

        // R3/R7 back-pressure: fill everything
        do_reset();
        for (int j = 0; j < 19; j++) push_smp($urandom_range(0, 255));
        repeat (20) @(posedge clk);
        check_counts("R7 backed up", 8, 8);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = 16'h2000; bus_wdata = 64'hAA;
        for (int i = 0; i < 4; i++) begin
            #1; chk("R3 stall on full", bus_stall, 1); @(negedge clk);
        end
        bus_req = 1'b0;
        check_counts("R3 no entry added", 8, 8);
        drain_all("R7 after stall");
        check_counts("R7 drained", 0, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule